// File: doc/BRIEF.md
# Bridge Configuration Header Registers

This block holds the configuration space of a PCI-to-PCI bridge function that uses the type-1 header layout. A protocol front end presents accepted configuration writes to it as a dword index, four byte enables and 32 bits of data. Reads are combinational from the same dword index. The block stores the bus numbers, the secondary latency timer, the command word, the three forwarding windows (I/O, memory, prefetchable memory) together with their upper extensions, and the bridge control word. It also returns the fixed identity fields: IDs, class code, header type and the capability bits in both status words.

Two pulses tell the neighbouring logic that something changed. The first, a remap request, fires when a write touches any byte that affects address forwarding, so that the window decoder can re-read its limits. The second, a secondary-bus reset, fires when the bridge-control reset bit goes from 0 to 1. A separate command input loads a preset that empties every window. Firmware uses it to close forwarding before it programs real ranges.

Top module: `p2p_hdr_regs`

## Requirements
- R1: While reset is asserted and after it is released, these fields read as zero: the primary, secondary and subordinate bus numbers, the secondary latency timer, the bridge control word, every address bit of the six base/limit fields, and all upper extension registers.
- R2: Dword 2 bits [31:8] read 0x060400. The header-type byte (dword 3, bits [23:16]) reads {MULTI_FN, 7'h01}.
- R3: The upper halves of dword 1 (status) and dword 7 (secondary status) always read 0x00A0, which has bit 5 (66 MHz) and bit 7 (fast back-to-back) set. Writes to them have no effect.
- R4: Dword 6 holds four fully writable bytes: primary bus in [7:0], secondary bus in [15:8], subordinate bus in [23:16] and secondary latency timer in [31:24]. Each byte is written only when its byte enable is set.
- R5: In each base/limit field only the address bits accept writes: bits [7:4] of the I/O bytes at dword 7 lanes 0/1, and bits [15:4] of the memory (dword 8) and prefetchable (dword 9) halfwords, with base in the low half and limit in the high half. The low nibble is a read-only type code: 1 for I/O when IO32=1, 1 for prefetchable when PREF64=1, and 0 for memory.
- R6: When enabled, the upper extension registers are fully writable per byte. These are the prefetchable base upper (dword 10), the prefetchable limit upper (dword 11) and the I/O base/limit upper halves (dword 12, base in [15:0]).
- R7: One cycle of the disable-forwarding input sets all base address bits to ones and clears all limit address bits and both prefetchable upper registers. The I/O upper halves stay unchanged. The preset takes precedence over a write to those fields in the same cycle, and the preset alone raises no remap request.
- R8: The remap request is high for exactly the cycle after a write whose enabled bytes include any of byte offsets 0x04–0x05, 0x1C–0x1D, 0x20–0x33 or 0x3E–0x3F. It stays low after a write that enables none of them.
- R9: The secondary-bus reset pulse is high for exactly the cycle after a write that takes bridge control bit 6 (byte 0x3E bit 6, carried on wdata[22] at dword 15) from 0 to 1. Rewriting 1, clearing the bit, or a write with byte lane 2 disabled raises no pulse.
- R10: Only command bits set in CMD_WMASK (default 0x0147) and bridge-control bits set in BCTL_WMASK (default 0x0FFF) accept writes. All other bits of those words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe, one accepted write per cycle |
| cfg_addr | input | 4 | Dword index into the 64-byte header, for both write and read |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, byte lane n in bits [8n+7:8n] |
| kill_fwd | input | 1 | Disable-forwarding preset command |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| remap_pulse | output | 1 | Window remap request pulse |
| sec_rst_pulse | output | 1 | Secondary-bus reset pulse |

## Verification
The hardest states to reach are the edges of the remap byte ranges, where a single byte lane decides between a pulse and silence. The stimulus therefore writes single-lane patterns at both edges of each range: the status bytes next to the command word, the secondary status next to the I/O pair, the last byte of the I/O upper dword and the first byte after it, and the interrupt bytes next to bridge control. The stimulus also applies a preset and a write in the same cycle, and drives the reset bit through the 0→1, 1→1 and 1→0 transitions, including one write with lane 2 masked.

// File: rtl/p2p_hdr_pkg.sv
package p2p_hdr_pkg;

   localparam int HDR_BYTES = 64;
   localparam int HDR_DW    = HDR_BYTES / 4;

   localparam logic [15:0] STAT_CAPS  = 16'h00A0;
   localparam logic [23:0] CLASS_P2P  = 24'h060400;
   localparam logic [6:0]  HDR_TYPE1  = 7'h01;
   localparam int          SBR_BIT    = 6;

   // byte offsets whose write changes forwarding
   function automatic logic [HDR_BYTES-1:0] remap_map();
      logic [HDR_BYTES-1:0] m;
      m = '0;
      for (int i = 0; i < HDR_BYTES; i++) begin
         if ((i >= 'h04 && i <= 'h05) || (i >= 'h1C && i <= 'h1D) ||
             (i >= 'h20 && i <= 'h33) || (i >= 'h3E && i <= 'h3F))
            m[i] = 1'b1;
      end
      return m;
   endfunction

   // byte offsets that hold writable storage
   function automatic logic [HDR_BYTES-1:0] store_map();
      logic [HDR_BYTES-1:0] m;
      m = '0;
      for (int i = 0; i < HDR_BYTES; i++) begin
         if ((i >= 'h04 && i <= 'h05) || (i >= 'h18 && i <= 'h1D) ||
             (i >= 'h20 && i <= 'h33) || (i >= 'h3E && i <= 'h3F))
            m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/p2p_hdr_wdec.sv
module p2p_hdr_wdec
   import p2p_hdr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [3:0]           addr,
   input  logic [3:0]           be,
   output logic [HDR_BYTES-1:0] byte_we,
   output logic                 remap_q
);
   localparam logic [HDR_BYTES-1:0] REMAP_MAP = remap_map();

   for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
      assign byte_we[i] = wr && (addr == 4'(i / 4)) && be[i % 4];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) remap_q <= 1'b0;
      else        remap_q <= |(byte_we & REMAP_MAP);
   end
endmodule

// File: rtl/p2p_hdr_span.sv
module p2p_hdr_span #(
   parameter int           BYTES     = 2,
   parameter logic [3:0]   TYPE_NIB  = 4'h0,
   parameter bit           KILL_ONES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BYTES-1:0]     we,
   input  logic [8*BYTES-1:0]   wd,
   input  logic                 kill,
   output logic [8*BYTES-1:0]   q
);
   localparam int AB = 8 * BYTES - 4;

   if (BYTES != 1 && BYTES != 2) begin : g_bad_bytes
      $error("p2p_hdr_span: BYTES must be 1 or 2");
   end

   logic [AB-1:0] a_q;

   if (BYTES == 1) begin : g_narrow
      always_ff @(posedge clk) begin
         if (!rst_n)     a_q <= '0;
         else if (kill)  a_q <= KILL_ONES ? '1 : '0;
         else if (we[0]) a_q <= wd[7:4];
      end
   end else begin : g_wide
      always_ff @(posedge clk) begin
         if (!rst_n)    a_q <= '0;
         else if (kill) a_q <= KILL_ONES ? '1 : '0;
         else begin
            if (we[0]) a_q[3:0]  <= wd[7:4];
            if (we[1]) a_q[11:4] <= wd[15:8];
         end
      end
   end

   assign q = {a_q, TYPE_NIB};
endmodule

// File: rtl/p2p_hdr_upper.sv
module p2p_hdr_upper #(
   parameter int BYTES    = 4,
   parameter bit EN       = 1'b1,
   parameter bit KILL_CLR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BYTES-1:0]     we,
   input  logic [8*BYTES-1:0]   wd,
   input  logic                 kill,
   output logic [8*BYTES-1:0]   q
);
   if (EN) begin : g_on
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else if (kill && KILL_CLR) q <= '0;
         else begin
            for (int b = 0; b < BYTES; b++)
               if (we[b]) q[8*b +: 8] <= wd[8*b +: 8];
         end
      end
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, we, wd, kill};
      assign q = '0;
   end
endmodule

// File: rtl/p2p_hdr_ctrl.sv
module p2p_hdr_ctrl
   import p2p_hdr_pkg::*;
#(
   parameter logic [15:0] CMD_WMASK  = 16'h0147,
   parameter logic [15:0] BCTL_WMASK = 16'h0FFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HDR_BYTES-1:0] byte_we,
   input  logic [31:0]          wdata,
   output logic [15:0]          cmd_q,
   output logic [31:0]          bus_q,
   output logic [15:0]          bctl_q,
   output logic                 sbr_q
);
   logic sbr_rise;
   assign sbr_rise = byte_we['h3E] && !bctl_q[SBR_BIT] && wdata[16+SBR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         bus_q  <= '0;
         bctl_q <= '0;
         sbr_q  <= 1'b0;
      end else begin
         if (byte_we['h04]) cmd_q[7:0]   <= wdata[7:0]   & CMD_WMASK[7:0];
         if (byte_we['h05]) cmd_q[15:8]  <= wdata[15:8]  & CMD_WMASK[15:8];
         for (int b = 0; b < 4; b++)
            if (byte_we['h18 + b]) bus_q[8*b +: 8] <= wdata[8*b +: 8];
         if (byte_we['h3E]) bctl_q[7:0]  <= wdata[23:16] & BCTL_WMASK[7:0];
         if (byte_we['h3F]) bctl_q[15:8] <= wdata[31:24] & BCTL_WMASK[15:8];
         sbr_q <= sbr_rise;
      end
   end
endmodule

// File: rtl/p2p_hdr_regs.sv
module p2p_hdr_regs
   import p2p_hdr_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1B36,
   parameter logic [15:0] DEVICE_ID  = 16'h0001,
   parameter logic [7:0]  REVISION   = 8'h00,
   parameter bit          MULTI_FN   = 1'b0,
   parameter bit          IO32       = 1'b1,
   parameter bit          PREF64     = 1'b1,
   parameter logic [15:0] CMD_WMASK  = 16'h0147,
   parameter logic [15:0] BCTL_WMASK = 16'h0FFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [3:0]  cfg_addr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   input  logic        kill_fwd,
   output logic [31:0] cfg_rdata,
   output logic        remap_pulse,
   output logic        sec_rst_pulse
);
   localparam logic [HDR_BYTES-1:0] STORE_MAP = store_map();
   localparam logic [3:0] IO_NIB   = IO32   ? 4'h1 : 4'h0;
   localparam logic [3:0] PREF_NIB = PREF64 ? 4'h1 : 4'h0;

   if (!BCTL_WMASK[SBR_BIT]) begin : g_bad_bctl
      $error("p2p_hdr_regs: secondary reset bit must be writable");
   end
   if (HDR_DW != 16) begin : g_bad_hdr
      $error("p2p_hdr_regs: header must span 16 dwords");
   end

   logic [HDR_BYTES-1:0] byte_we;
   logic [15:0] cmd_q, bctl_q;
   logic [31:0] bus_q;
   logic [7:0]  io_base_q, io_lim_q;
   logic [15:0] mem_base_q, mem_lim_q, pref_base_q, pref_lim_q;
   logic [31:0] pref_bup_q, pref_lup_q;
   logic [15:0] io_bup_q, io_lup_q;

   logic unused_bytes;
   assign unused_bytes = ^(byte_we & ~STORE_MAP);

   p2p_hdr_wdec u_wdec (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be),
      .byte_we(byte_we), .remap_q(remap_pulse)
   );

   p2p_hdr_ctrl #(.CMD_WMASK(CMD_WMASK), .BCTL_WMASK(BCTL_WMASK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .wdata(cfg_wdata),
      .cmd_q(cmd_q), .bus_q(bus_q), .bctl_q(bctl_q), .sbr_q(sec_rst_pulse)
   );

   p2p_hdr_span #(.BYTES(1), .TYPE_NIB(IO_NIB), .KILL_ONES(1'b1)) u_io_base (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h1C]), .wd(cfg_wdata[7:0]),
      .kill(kill_fwd), .q(io_base_q));
   p2p_hdr_span #(.BYTES(1), .TYPE_NIB(IO_NIB), .KILL_ONES(1'b0)) u_io_lim (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h1D]), .wd(cfg_wdata[15:8]),
      .kill(kill_fwd), .q(io_lim_q));
   p2p_hdr_span #(.BYTES(2), .TYPE_NIB(4'h0), .KILL_ONES(1'b1)) u_mem_base (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h21:'h20]), .wd(cfg_wdata[15:0]),
      .kill(kill_fwd), .q(mem_base_q));
   p2p_hdr_span #(.BYTES(2), .TYPE_NIB(4'h0), .KILL_ONES(1'b0)) u_mem_lim (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h23:'h22]), .wd(cfg_wdata[31:16]),
      .kill(kill_fwd), .q(mem_lim_q));
   p2p_hdr_span #(.BYTES(2), .TYPE_NIB(PREF_NIB), .KILL_ONES(1'b1)) u_pref_base (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h25:'h24]), .wd(cfg_wdata[15:0]),
      .kill(kill_fwd), .q(pref_base_q));
   p2p_hdr_span #(.BYTES(2), .TYPE_NIB(PREF_NIB), .KILL_ONES(1'b0)) u_pref_lim (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h27:'h26]), .wd(cfg_wdata[31:16]),
      .kill(kill_fwd), .q(pref_lim_q));

   p2p_hdr_upper #(.BYTES(4), .EN(PREF64), .KILL_CLR(1'b1)) u_pref_bup (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h2B:'h28]), .wd(cfg_wdata),
      .kill(kill_fwd), .q(pref_bup_q));
   p2p_hdr_upper #(.BYTES(4), .EN(PREF64), .KILL_CLR(1'b1)) u_pref_lup (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h2F:'h2C]), .wd(cfg_wdata),
      .kill(kill_fwd), .q(pref_lup_q));
   p2p_hdr_upper #(.BYTES(2), .EN(IO32), .KILL_CLR(1'b0)) u_io_bup (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h31:'h30]), .wd(cfg_wdata[15:0]),
      .kill(kill_fwd), .q(io_bup_q));
   p2p_hdr_upper #(.BYTES(2), .EN(IO32), .KILL_CLR(1'b0)) u_io_lup (
      .clk(clk), .rst_n(rst_n), .we(byte_we['h33:'h32]), .wd(cfg_wdata[31:16]),
      .kill(kill_fwd), .q(io_lup_q));

   always_comb begin
      case (cfg_addr)
         4'd0:    cfg_rdata = {DEVICE_ID, VENDOR_ID};
         4'd1:    cfg_rdata = {STAT_CAPS, cmd_q};
         4'd2:    cfg_rdata = {CLASS_P2P, REVISION};
         4'd3:    cfg_rdata = {8'h00, MULTI_FN, HDR_TYPE1, 16'h0000};
         4'd6:    cfg_rdata = bus_q;
         4'd7:    cfg_rdata = {STAT_CAPS, io_lim_q, io_base_q};
         4'd8:    cfg_rdata = {mem_lim_q, mem_base_q};
         4'd9:    cfg_rdata = {pref_lim_q, pref_base_q};
         4'd10:   cfg_rdata = pref_bup_q;
         4'd11:   cfg_rdata = pref_lup_q;
         4'd12:   cfg_rdata = {io_lup_q, io_bup_q};
         4'd15:   cfg_rdata = {bctl_q, 16'h0000};
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/p2p_hdr_chk.sv
module p2p_hdr_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic [3:0]  cfg_addr,
   input logic [3:0]  cfg_be,
   input logic        kill_fwd,
   input logic        remap_pulse,
   input logic        sec_rst_pulse,
   input logic [15:0] bctl_q,
   input logic [15:0] mem_base_q,
   input logic [15:0] mem_lim_q,
   input logic [15:0] pref_base_q,
   input logic [15:0] pref_lim_q,
   input logic [31:0] pref_lup_q
);
   // R8: a remap request needs a write in the prior cycle
   a_r8_remap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> $past(cfg_wr));

   // R8: a write to the bus-number dword never requests a remap
   a_r8_no_remap_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 4'd6) |=> !remap_pulse);

   // R9: reset pulse only follows a lane-2 write to bridge control
   a_r9_sbr_source: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rst_pulse |-> $past(cfg_wr && cfg_addr == 4'd15 && cfg_be[2]));

   // R9: reset pulse marks a 0-to-1 edge of the stored bit
   a_r9_sbr_edge: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rst_pulse |-> (bctl_q[6] && !$past(bctl_q[6])));

   // R7: after the preset every memory window is empty
   a_r7_kill_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $past(kill_fwd) |-> (mem_base_q[15:4] == 12'hFFF && mem_lim_q[15:4] == 12'h000 &&
                           pref_base_q[15:4] == 12'hFFF && pref_lim_q[15:4] == 12'h000 &&
                           pref_lup_q == 32'h0));
endmodule

bind p2p_hdr_regs p2p_hdr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
   .kill_fwd(kill_fwd), .remap_pulse(remap_pulse), .sec_rst_pulse(sec_rst_pulse),
   .bctl_q(bctl_q), .mem_base_q(mem_base_q), .mem_lim_q(mem_lim_q),
   .pref_base_q(pref_base_q), .pref_lim_q(pref_lim_q), .pref_lup_q(pref_lup_q)
);

// File: tb/p2p_hdr_regs_tb_top.sv
module p2p_hdr_regs_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic        kill_fwd = 1'b0;
   logic [31:0] cfg_rdata;
   logic        remap_pulse, sec_rst_pulse;

   int errors = 0;
   int checks = 0;
   logic seen_remap, seen_sbr;

   always #(CLK_P/2) clk = ~clk;

   p2p_hdr_regs dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .kill_fwd(kill_fwd), .cfg_rdata(cfg_rdata),
      .remap_pulse(remap_pulse), .sec_rst_pulse(sec_rst_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one write, returns at the negedge where the pulses are visible
   task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d,
                     input logic kill = 1'b0);
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; kill_fwd = kill;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0; kill_fwd = 1'b0;
      seen_remap = remap_pulse;
      seen_sbr = sec_rst_pulse;
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
      cfg_addr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      rd("R1 bus", 4'd6, 32'h0);
      rd("R1 io", 4'd7, 32'h00A0_0101);
      rd("R1 mem", 4'd8, 32'h0);
      rd("R1 pref", 4'd9, 32'h0001_0001);
      rd("R1 pref up", 4'd10, 32'h0);
      rd("R1 io up", 4'd12, 32'h0);
      rd("R1 bctl", 4'd15, 32'h0);
      chk("R1 remap idle", {31'b0, remap_pulse}, 32'h0);
   endtask

   task automatic t_ident();
      rd("R2 class", 4'd2, 32'h0604_0000);
      rd("R2 header", 4'd3, 32'h0001_0000);
      wr(4'd1, 4'b1100, 32'hFFFF_0000);
      rd("R3 status ro", 4'd1, 32'h00A0_0000);
      chk("R8 status no remap", {31'b0, seen_remap}, 32'h0);
      wr(4'd7, 4'b1100, 32'h5555_0000);
      rd("R3 sec status ro", 4'd7, 32'h00A0_0101);
      chk("R8 sec status no remap", {31'b0, seen_remap}, 32'h0);
   endtask

   task automatic t_bus();
      wr(4'd6, 4'b1111, 32'h4033_2211);
      rd("R4 bus all", 4'd6, 32'h4033_2211);
      chk("R8 bus no remap", {31'b0, seen_remap}, 32'h0);
      wr(4'd6, 4'b0010, 32'hAAAA_AAAA);
      rd("R4 bus lane1", 4'd6, 32'h4033_AA11);
   endtask

   task automatic t_windows();
      wr(4'd8, 4'b1111, 32'hABCD_1234);
      rd("R5 mem", 4'd8, 32'hABC0_1230);
      chk("R8 mem remap", {31'b0, seen_remap}, 32'h1);
      wr(4'd7, 4'b0011, 32'hFFFF_5A3C);
      rd("R5 io", 4'd7, 32'h00A0_5131);
      chk("R8 io remap", {31'b0, seen_remap}, 32'h1);
      wr(4'd9, 4'b0110, 32'hFFFF_FFFF);
      rd("R5 pref partial", 4'd9, 32'h00F1_FF01);
   endtask

   task automatic t_upper();
      wr(4'd10, 4'b1111, 32'hDEAD_BEEF);
      rd("R6 pref bup", 4'd10, 32'hDEAD_BEEF);
      wr(4'd11, 4'b0101, 32'h1122_3344);
      rd("R6 pref lup", 4'd11, 32'h0022_0044);
      wr(4'd12, 4'b1000, 32'h7700_0000);
      rd("R6 io up", 4'd12, 32'h7700_0000);
      chk("R8 last range byte remap", {31'b0, seen_remap}, 32'h1);
      wr(4'd13, 4'b0001, 32'hFFFF_FFFF);
      chk("R8 past range no remap", {31'b0, seen_remap}, 32'h0);
   endtask

   task automatic t_kill();
      kill_fwd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      kill_fwd = 1'b0;
      chk("R7 kill no remap", {31'b0, remap_pulse}, 32'h0);
      rd("R7 io", 4'd7, 32'h00A0_01F1);
      rd("R7 mem", 4'd8, 32'h0000_FFF0);
      rd("R7 pref", 4'd9, 32'h0001_FFF1);
      rd("R7 pref bup", 4'd10, 32'h0);
      rd("R7 pref lup", 4'd11, 32'h0);
      rd("R7 io up kept", 4'd12, 32'h7700_0000);
      wr(4'd8, 4'b1111, 32'h1230_4560, 1'b1);
      rd("R7 kill beats write", 4'd8, 32'h0000_FFF0);
      chk("R8 write with kill remap", {31'b0, seen_remap}, 32'h1);
   endtask

   task automatic t_cmd();
      wr(4'd1, 4'b0011, 32'hFFFF_FFFF);
      rd("R10 cmd mask", 4'd1, 32'h00A0_0147);
      chk("R8 cmd remap", {31'b0, seen_remap}, 32'h1);
      wr(4'd15, 4'b1000, 32'hFF00_0000);
      rd("R10 bctl mask", 4'd15, 32'h0F00_0000);
      chk("R9 lane2 off no pulse", {31'b0, seen_sbr}, 32'h0);
   endtask

   task automatic t_sbr();
      wr(4'd15, 4'b0011, 32'hFFFF_FFFF);
      chk("R8 int bytes no remap", {31'b0, seen_remap}, 32'h0);
      wr(4'd15, 4'b0100, 32'h0040_0000);
      chk("R9 rise pulse", {31'b0, seen_sbr}, 32'h1);
      chk("R8 bctl remap", {31'b0, seen_remap}, 32'h1);
      @(negedge clk);
      chk("R9 single cycle", {31'b0, sec_rst_pulse}, 32'h0);
      wr(4'd15, 4'b0100, 32'h0040_0000);
      chk("R9 hold no pulse", {31'b0, seen_sbr}, 32'h0);
      wr(4'd15, 4'b0100, 32'h0000_0000);
      chk("R9 fall no pulse", {31'b0, seen_sbr}, 32'h0);
      wr(4'd15, 4'b1100, 32'h0040_0000);
      chk("R9 second rise", {31'b0, seen_sbr}, 32'h1);
      rd("R9 bctl value", 4'd15, 32'h0040_0000);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      t_reset();
      t_ident();
      t_bus();
      t_windows();
      t_upper();
      t_kill();
      t_cmd();
      t_sbr();
      do_reset();
      t_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule